// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block arbitrates interrupt requests for a small 8-bit processor core. It serves three sources, in index order: timer 0 overflow, timer 1 overflow and time base overflow. Each source has a request flag and a local enable. Acceptance also needs a global enable and a clear stack-full status. When a request is accepted on an instruction-boundary strobe from the core, the block raises a one-cycle vector call request together with the index of the winning source. On the next clock edge it clears that source's flag and the global enable, so further interrupts stay masked until software enables them again.

Software reaches the block through a single byte-wide register port. Each source has its own control byte, which holds the flag and the enable bit. One more byte holds the global enable. A separate wake-up output lets the core leave sleep mode when any enabled source is pending. Only the return address is pushed by the core when it takes the call. Software must save any working or status registers it needs. The counters, the return stack and the datapath are outside this block.

Top module: `irq_vector_ctrl`

## Requirements
- R1: When `insn_boundary_i` is high, the global enable is 1, `stack_full_i` is 0 and some source has both its flag and its enable set, `call_req_o` is high in that same cycle and `vec_idx_o` gives the winning source index. The pulse lasts one cycle.
- R2: While `stack_full_i` is 1, `call_req_o` stays 0, whatever the flags and enables are.
- R3: Without `insn_boundary_i`, with the global enable at 0, or with no source both flagged and enabled, `call_req_o` stays 0.
- R4: A one-cycle pulse on `ovf_i[k]` sets flag k at the next edge, whether or not source k is enabled.
- R5: At the edge after a call pulse, the flag of the serviced source and the global enable are both 0. The other sources' flags are unchanged.
- R6: A set flag stays set while its enable is 0. It is cleared only by service or by a software write of 0 to bit 5.
- R7: Register addresses 0, 1 and 2 are the source control bytes for timer 0, timer 1 and time base, with the flag at bit 5 and the enable at bit 1. Address 3 holds the global enable at bit 0. All other bits read 0, and every register reads 0x00 after reset. `rdata_o` shows the register selected by `addr_i` combinationally.
- R8: With several sources ready, the fixed priority is timer 0 first, then timer 1, then time base. The vector indices are 0, 1 and 2.
- R9: `wake_o` is 1 exactly when some source has both its flag and its enable set. It does not depend on the global enable or on `stack_full_i`.
- R10: A software write of 1 to bit 5 of a source control byte sets that flag.
- R11: An overflow pulse arriving in the same cycle as a service clear or a software clear of the same flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovf_i | input | 3 | Overflow event pulses: bit 0 timer 0, bit 1 timer 1, bit 2 time base |
| stack_full_i | input | 1 | Return stack has no free entry |
| insn_boundary_i | input | 1 | Core is at an instruction boundary and may take a call |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for writes and reads |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data of the register at `addr_i` |
| call_req_o | output | 1 | One-cycle vector call request |
| vec_idx_o | output | 2 | Index of the source being vectored |
| wake_o | output | 1 | Wake-up request for sleep mode |
| gie_o | output | 1 | Current global enable |

## Verification
On every cycle, the assertions check these relations:
- the call pulse never appears while the stack is full, without the boundary strobe, or without the global enable;
- an overflow always leaves its flag set;
- a flag that nothing touches keeps its value;
- each call masks the global enable and clears the serviced flag;
- the vectored index is always the highest-priority ready source.

The register layout and the reset values can only be shown by the bench scenarios. The same holds for software set and clear of flags, for the exact order in which three pending sources are served one after another, for the wake-up output while the global enable is off, and for the collision cases where an overflow meets a clear in the same cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC     = 3;
    localparam int FLAG_BIT = 5;
    localparam int EN_BIT   = 1;
    localparam int GIE_BIT  = 0;
    localparam int DW       = 8;
    localparam int AW       = $clog2(NSRC + 1);
    localparam int IW       = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        logic flag;
        logic en;
    } slot_t;

    typedef struct packed {
        logic gie;
    } top_t;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ovf_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          svc_i,
    output logic          flag_o,
    output logic          en_o,
    output logic [DW-1:0] rdata_o
);
    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.flag = wdata_i[FLAG_BIT];
            st_d.en   = wdata_i[EN_BIT];
        end
        if (svc_i) st_d.flag = 1'b0;
        if (ovf_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o           = '0;
        rdata_o[FLAG_BIT] = st_q.flag;
        rdata_o[EN_BIT]   = st_q.en;
    end

    assign flag_o = st_q.flag;
    assign en_o   = st_q.en;

    assert_ovf_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> flag_o);
    assert_svc_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_i && !ovf_i) |=> !flag_o);
    assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_i && !wr_i && !svc_i) |=> $stable(flag_o));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_pkg::*;
(
    input  logic [NSRC-1:0] req_i,
    output logic [NSRC-1:0] grant_o,
    output logic [IW-1:0]   idx_o,
    output logic            any_o
);
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (req_i[k]) begin
                grant_o    = '0;
                grant_o[k] = 1'b1;
                idx_o      = IW'(k);
            end
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ovf_i,
    input  logic            stack_full_i,
    input  logic            insn_boundary_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o,
    output logic            call_req_o,
    output logic [IW-1:0]   vec_idx_o,
    output logic            wake_o,
    output logic            gie_o
);
    localparam logic [AW-1:0] GIE_ADDR = AW'(NSRC);

    top_t st_d, st_q;

    logic [NSRC-1:0] flag_w, en_w, ready_w, grant_w, svc_w;
    logic [DW-1:0]   slot_rd [NSRC];
    logic            any_w, accept_w;
    logic [IW-1:0]   idx_w;

    for (genvar k = 0; k < NSRC; k++) begin : g_slot
        irq_src_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .ovf_i   (ovf_i[k]),
            .wr_i    (wr_en_i && (addr_i == AW'(k))),
            .wdata_i (wdata_i),
            .svc_i   (svc_w[k]),
            .flag_o  (flag_w[k]),
            .en_o    (en_w[k]),
            .rdata_o (slot_rd[k])
        );
    end

    assign ready_w = flag_w & en_w;

    irq_prio_arb u_arb (
        .req_i   (ready_w),
        .grant_o (grant_w),
        .idx_o   (idx_w),
        .any_o   (any_w)
    );

    assign accept_w = insn_boundary_i && st_q.gie && !stack_full_i && any_w;
    assign svc_w    = accept_w ? grant_w : '0;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && addr_i == GIE_ADDR) st_d.gie = wdata_i[GIE_BIT];
        if (accept_w) st_d.gie = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == GIE_ADDR) rdata_o[GIE_BIT] = st_q.gie;
        else if (addr_i < GIE_ADDR) rdata_o = slot_rd[IW'(addr_i)];
    end

    assign call_req_o = accept_w;
    assign vec_idx_o  = idx_w;
    assign wake_o     = any_w;
    assign gie_o      = st_q.gie;

    logic [NSRC-1:0] lower_mask_w;
    assign lower_mask_w = (NSRC'(1) << vec_idx_o) - NSRC'(1);

    assert_stack_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stack_full_i |-> !call_req_o);
    assert_call_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        call_req_o |-> (insn_boundary_i && gie_o));
    assert_call_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        call_req_o |=> !gie_o);
    assert_call_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        call_req_o |=> !call_req_o);
    assert_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        call_req_o |-> (ready_w[vec_idx_o] && ((ready_w & lower_mask_w) == '0)));
    assert_call_wakes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        call_req_o |-> wake_o);
endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/100ps
module irq_vector_ctrl_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [2:0] ovf = '0;
    logic       stack_full = 0;
    logic       boundary = 0;
    logic       wr_en = 0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       call_req;
    logic [1:0] vec_idx;
    logic       wake;
    logic       gie;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ovf_i(ovf), .stack_full_i(stack_full),
        .insn_boundary_i(boundary), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .call_req_o(call_req),
        .vec_idx_o(vec_idx), .wake_o(wake), .gie_o(gie)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        addr = a; #1;
        chk(tag, rdata, exp);
    endtask

    task automatic pulse_ovf(input logic [2:0] m);
        @(negedge clk); ovf = m;
        @(negedge clk); ovf = '0;
    endtask

    task automatic strobe(input logic exp_call, input logic [1:0] exp_vec, input string tag);
        @(negedge clk); boundary = 1; #1;
        chk(tag, call_req, exp_call);
        if (exp_call) chk({tag, " vec"}, vec_idx, exp_vec);
        @(negedge clk); boundary = 0; #1;
        chk({tag, " single"}, call_req, 0);
    endtask

    task automatic clear_all();
        wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h00);
    endtask

    task automatic t_reset();
        rd_chk(0, 8'h00, "R7 reset tmr0");
        rd_chk(1, 8'h00, "R7 reset tmr1");
        rd_chk(2, 8'h00, "R7 reset tbase");
        rd_chk(3, 8'h00, "R7 reset gie");
        chk("R3 reset call", call_req, 0);
        chk("R9 reset wake", wake, 0);
    endtask

    task automatic t_layout();
        wr(2, 8'hFF); rd_chk(2, 8'h22, "R7 tbase layout");
        wr(3, 8'hFF); rd_chk(3, 8'h01, "R7 gie layout");
        wr(0, 8'hDD); rd_chk(0, 8'h00, "R7 unused bits");
        clear_all();
    endtask

    task automatic t_flag_disabled();
        pulse_ovf(3'b010);
        rd_chk(1, 8'h20, "R4 flag set while disabled");
        chk("R9 no wake when disabled", wake, 0);
        repeat (3) @(negedge clk);
        rd_chk(1, 8'h20, "R6 flag holds");
        wr(1, 8'h22); #1;
        chk("R9 wake with gie off", wake, 1);
        wr(1, 8'h02);
        rd_chk(1, 8'h02, "R6 software clear");
        clear_all();
    endtask

    task automatic t_accept();
        wr(0, 8'h02); wr(1, 8'h00);
        pulse_ovf(3'b011);
        wr(3, 8'h01);
        strobe(1, 0, "R1 accept tmr0");
        rd_chk(0, 8'h02, "R5 tmr0 flag cleared");
        rd_chk(1, 8'h20, "R5 tmr1 flag untouched");
        chk("R5 gie cleared", gie, 0);
        clear_all();
    endtask

    task automatic t_stack();
        wr(2, 8'h22); wr(3, 8'h01);
        @(negedge clk); stack_full = 1;
        strobe(0, 0, "R2 blocked by full stack");
        chk("R9 wake with full stack", wake, 1);
        rd_chk(2, 8'h22, "R2 flag kept");
        @(negedge clk); stack_full = 0;
        strobe(1, 2, "R1 accept after stack frees");
        clear_all();
    endtask

    task automatic t_gating();
        wr(1, 8'h22); wr(3, 8'h01);
        repeat (2) @(negedge clk); #1;
        chk("R3 no call without boundary", call_req, 0);
        wr(3, 8'h00);
        strobe(0, 0, "R3 no call with gie off");
        wr(1, 8'h20); wr(3, 8'h01);
        strobe(0, 0, "R3 no call with enable off");
        clear_all();
    endtask

    task automatic t_priority();
        wr(0, 8'h02); wr(1, 8'h02); wr(2, 8'h02);
        pulse_ovf(3'b111);
        wr(3, 8'h01); strobe(1, 0, "R8 first tmr0");
        wr(3, 8'h01); strobe(1, 1, "R8 then tmr1");
        wr(3, 8'h01); strobe(1, 2, "R8 then tbase");
        #1; chk("R9 wake cleared", wake, 0);
        clear_all();
    endtask

    task automatic t_sw_set();
        wr(1, 8'h22);
        rd_chk(1, 8'h22, "R10 software set");
        wr(3, 8'h01);
        strobe(1, 1, "R10 software raised call");
        clear_all();
    endtask

    task automatic t_race();
        wr(0, 8'h22); wr(3, 8'h01);
        @(negedge clk); boundary = 1; ovf = 3'b001; #1;
        chk("R11 call taken", call_req, 1);
        @(negedge clk); boundary = 0; ovf = '0;
        rd_chk(0, 8'h22, "R11 overflow beats service");
        @(negedge clk); wr_en = 1; addr = 0; wdata = 8'h02; ovf = 3'b001;
        @(negedge clk); wr_en = 0; ovf = '0;
        rd_chk(0, 8'h22, "R11 overflow beats software clear");
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_layout();
        t_flag_disabled();
        t_accept();
        t_stack();
        t_gating();
        t_priority();
        t_sw_set();
        t_race();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule